// File: doc/BRIEF.md
# Video Clamp and Gain Controller

This block closes the digital side of the level control loops for a two-channel analog video front end. It watches the 8-bit sample streams from the luma converter and the chroma converter. During the back-porch clamp window it tells each channel's clamp circuit whether to raise or lower its level. The luma level is pulled towards 60 and the chroma level towards 128. Each request is a registered pulse, and both pulses are low when the level already matches its target.

The luma amplifier gain is a 9-bit code. In automatic mode it is driven by the lowest sample seen during each sync-bottom gain window. If that level falls below a dead band around the sync target, the gain rises by one step. If it lies above the band, the gain falls by one step. A full-scale luma sample seen during active video marks an overshoot. That overshoot forces one step down at the next gain window, whatever the sync level is. In manual mode both amplifier gains copy static register values. The chroma gain always copies its register value. While vertical blanking is asserted, every output and all internal loop state hold still.

Top module: `vid_level_ctrl`

## Requirements
- R1: With the clamp window high and vertical blanking low, a luma sample below 60 raises `luma_clamp_up`, and a sample above 60 raises `luma_clamp_dn`. A sample of exactly 60 raises neither. Each result appears on the edge that takes the sample.
- R2: The chroma channel behaves like R1 against a target of 128, on `chroma_clamp_up` and `chroma_clamp_dn`.
- R3: With the clamp window low and vertical blanking low, all four clamp outputs are low after the next edge, whatever the samples are.
- R4: While vertical blanking is high, the following do not change: the clamp outputs, both gain codes, the window minimum and the overshoot flag. A gain window or a full-scale sample during blanking has no effect.
- R5: In automatic mode, a gain window whose minimum luma sample is below 14 (target 16 minus dead band 2) raises the luma gain by 4. The new value appears on the first edge that samples the window low.
- R6: In automatic mode, a window minimum above 18 lowers the luma gain by 4. A minimum from 14 to 18 inclusive leaves the gain unchanged.
- R7: The automatic luma gain saturates at 16 and at 496 and never moves past either limit.
- R8: A luma sample of 255 with the active-video flag high sets an overshoot flag. The next gain window end lowers the gain by 4, even if the sync level would raise it. That clears the flag, so only one step is taken.
- R9: With `agc_en` low, `luma_gain` follows `man_luma_gain` one edge later. Gain windows have no effect, and the overshoot flag is cleared. `chroma_gain` follows `man_chroma_gain` one edge later in both modes. Automatic mode resumes from the last manual value.
- R10: Under reset, all clamp outputs are low and both gain codes are 256.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| luma_smp | input | 8 | Luma converter sample |
| chroma_smp | input | 8 | Chroma converter sample |
| clamp_win | input | 1 | Back-porch clamp window strobe |
| gain_win | input | 1 | Sync-bottom gain window strobe |
| vblank | input | 1 | Vertical blanking, freezes everything |
| active_vid | input | 1 | Active-video qualifier for overshoot detection |
| agc_en | input | 1 | 1 = automatic luma gain, 0 = manual |
| man_luma_gain | input | 9 | Static luma gain register value |
| man_chroma_gain | input | 9 | Static chroma gain register value |
| luma_clamp_up | output | 1 | Luma clamp-up request |
| luma_clamp_dn | output | 1 | Luma clamp-down request |
| chroma_clamp_up | output | 1 | Chroma clamp-up request |
| chroma_clamp_dn | output | 1 | Chroma clamp-down request |
| luma_gain | output | 9 | Luma amplifier gain code |
| chroma_gain | output | 9 | Chroma amplifier gain code |

## Verification
Clamp requests and the manual or chroma gain copies are due one edge after the inputs that cause them. A loop gain step is due on the first edge that samples the gain window low. An overshoot acts only at the end of the following window. The driver changes inputs just after a rising edge and queues each expected value right after the edge that must produce it. The monitor compares at the falling edge that follows, so every comparison lands in the cycle worked out from the register count.

// File: rtl/vlc_pkg.sv
// Package: shared constants and types for the video clamp and gain controller.
// Assumes two channels, indexed luma first and chroma second.
package vlc_pkg;
    localparam int NUM_CH    = 2;
    localparam int CH_LUMA   = 0;
    localparam int CH_CHROMA = 1;

    // One clamp request pair for a channel.
    typedef struct packed {
        logic up;
        logic dn;
    } clamp_req_t;
endpackage

// File: rtl/vlc_clamp_cmp.sv
// Module: per-channel clamp comparator. It compares each sample taken inside
// the clamp window against a fixed target and registers an up/down request.
// Assumes: freeze (vertical blanking) has priority and holds the request.
module vlc_clamp_cmp
    import vlc_pkg::*;
#(
    parameter int SMP_W  = 8,
    parameter int TARGET = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp,
    input  logic             win,
    input  logic             freeze,
    output clamp_req_t       req
);
    localparam logic [SMP_W-1:0] TGT_V = SMP_W'(TARGET);

    // Register the compare result in the window and clear it outside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= '0;
        end else if (!freeze) begin
            if (win) begin
                req.up <= (smp < TGT_V);
                req.dn <= (smp > TGT_V);
            end else begin
                req <= '0;
            end
        end
    end

    // R3: outside the window the requests drop.
    a_r3_idle_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && !freeze) |=> (req == '0));

    // R4: blanking holds the request.
    a_r4_clamp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(req));
endmodule

// File: rtl/vlc_sync_meas.sv
// Module: luma level measurement. It tracks the lowest luma sample in each
// gain window, flags the window's end, and keeps an overshoot flag that is
// set by a full-scale sample during active video.
// Assumes: the gain loop consumes the flag at each automatic window end.
module vlc_sync_meas #(
    parameter int SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] luma,
    input  logic             gain_win,
    input  logic             active_vid,
    input  logic             freeze,
    input  logic             agc_en,
    output logic             win_end,
    output logic [SMP_W-1:0] sync_min,
    output logic             peak_flag
);
    localparam logic [SMP_W-1:0] FULL_SCALE = '1;

    logic win_d;
    logic peak_hit;

    assign win_end  = win_d && !gain_win && !freeze;
    assign peak_hit = active_vid && (luma == FULL_SCALE);

    // Delay the window strobe so its falling edge can be found; this tracks even in blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) win_d <= 1'b0;
        else        win_d <= gain_win;
    end

    // Keep the smallest sample of the current window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_min <= FULL_SCALE;
        end else if (!freeze && gain_win) begin
            if (!win_d || luma < sync_min) sync_min <= luma;
        end
    end

    // Set the overshoot flag on a full-scale sample and clear it when consumed or in manual mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_flag <= 1'b0;
        end else if (!freeze) begin
            if (!agc_en) peak_flag <= 1'b0;
            else         peak_flag <= (peak_flag && !win_end) || peak_hit;
        end
    end

    // R8: the flag only rises after a full-scale active sample.
    a_r8_peak_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(peak_flag) |-> ($past(active_vid) && ($past(luma) == FULL_SCALE)));
endmodule

// File: rtl/vlc_gain_loop.sv
// Module: luma gain loop. At each gain window end in automatic mode it steps the
// gain code by one step: down on overshoot or a high sync level, up on a low one.
// The code saturates at both limits. In manual mode it copies the register value.
// Assumes: win_end is already qualified by blanking.
module vlc_gain_loop #(
    parameter int SMP_W    = 8,
    parameter int GAIN_W   = 9,
    parameter int GAIN_MIN = 16,
    parameter int GAIN_MAX = 496,
    parameter int GAIN_NOM = 256,
    parameter int STEP     = 4,
    parameter int SYNC_TGT = 16,
    parameter int DEAD     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              agc_en,
    input  logic [GAIN_W-1:0] man_gain,
    input  logic              win_end,
    input  logic [SMP_W-1:0]  sync_min,
    input  logic              peak_flag,
    output logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] G_MIN  = GAIN_W'(GAIN_MIN);
    localparam logic [GAIN_W-1:0] G_MAX  = GAIN_W'(GAIN_MAX);
    localparam logic [GAIN_W-1:0] G_NOM  = GAIN_W'(GAIN_NOM);
    localparam logic [GAIN_W-1:0] G_STEP = GAIN_W'(STEP);
    localparam logic [SMP_W-1:0]  LVL_LO = SMP_W'(SYNC_TGT - DEAD);
    localparam logic [SMP_W-1:0]  LVL_HI = SMP_W'(SYNC_TGT + DEAD);

    logic [GAIN_W-1:0] gain_up;
    logic [GAIN_W-1:0] gain_dn;
    logic              want_dn;
    logic              want_up;

    // Compute the saturated neighbours of the current code and the step direction.
    always_comb begin
        gain_up = (gain >= G_MAX - G_STEP) ? G_MAX : gain + G_STEP;
        gain_dn = (gain <= G_MIN + G_STEP) ? G_MIN : gain - G_STEP;
        want_dn = peak_flag || (sync_min > LVL_HI);
        want_up = !peak_flag && (sync_min < LVL_LO);
    end

    // Update the gain code: hold in blanking, copy in manual, step at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain <= G_NOM;
        end else if (!freeze) begin
            if (!agc_en) begin
                gain <= man_gain;
            end else if (win_end) begin
                if (want_dn)      gain <= gain_dn;
                else if (want_up) gain <= gain_up;
            end
        end
    end

    // R4: blanking holds the gain.
    a_r4_gain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(gain));

    // R5: in automatic mode the code moves only at a window end.
    a_r5_hold_between_windows: assert property (@(posedge clk) disable iff (!rst_n)
        (agc_en && !win_end) |=> $stable(gain));

    // R9: manual mode copies the register value one edge later.
    a_r9_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!agc_en && !freeze) |=> (gain == $past(man_gain)));
endmodule

// File: rtl/vid_level_ctrl.sv
// Module: top of the video clamp and gain controller. It holds one clamp
// comparator per channel, the luma level measurement, the luma gain loop and
// the chroma gain register.
// Assumes: all strobes are synchronous to clk; vblank freezes every output.
module vid_level_ctrl
    import vlc_pkg::*;
#(
    parameter int SMP_W        = 8,
    parameter int GAIN_W       = 9,
    parameter int LUMA_CLAMP   = 60,
    parameter int CHROMA_CLAMP = 128,
    parameter int GAIN_MIN     = 16,
    parameter int GAIN_MAX     = 496,
    parameter int GAIN_NOM     = 256,
    parameter int GAIN_STEP    = 4,
    parameter int SYNC_TGT     = 16,
    parameter int SYNC_DEAD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  luma_smp,
    input  logic [SMP_W-1:0]  chroma_smp,
    input  logic              clamp_win,
    input  logic              gain_win,
    input  logic              vblank,
    input  logic              active_vid,
    input  logic              agc_en,
    input  logic [GAIN_W-1:0] man_luma_gain,
    input  logic [GAIN_W-1:0] man_chroma_gain,
    output logic              luma_clamp_up,
    output logic              luma_clamp_dn,
    output logic              chroma_clamp_up,
    output logic              chroma_clamp_dn,
    output logic [GAIN_W-1:0] luma_gain,
    output logic [GAIN_W-1:0] chroma_gain
);
    localparam logic [GAIN_W-1:0] G_NOM = GAIN_W'(GAIN_NOM);

    logic [SMP_W-1:0] smp_bus [NUM_CH];
    clamp_req_t       req     [NUM_CH];
    logic             win_end;
    logic [SMP_W-1:0] sync_min;
    logic             peak_flag;

    assign smp_bus[CH_LUMA]   = luma_smp;
    assign smp_bus[CH_CHROMA] = chroma_smp;

    // One comparator per channel, each with its own fixed target.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_clamp
        localparam int TGT = (ch == CH_LUMA) ? LUMA_CLAMP : CHROMA_CLAMP;
        vlc_clamp_cmp #(.SMP_W(SMP_W), .TARGET(TGT)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp    (smp_bus[ch]),
            .win    (clamp_win),
            .freeze (vblank),
            .req    (req[ch])
        );
    end

    assign luma_clamp_up   = req[CH_LUMA].up;
    assign luma_clamp_dn   = req[CH_LUMA].dn;
    assign chroma_clamp_up = req[CH_CHROMA].up;
    assign chroma_clamp_dn = req[CH_CHROMA].dn;

    vlc_sync_meas #(.SMP_W(SMP_W)) u_meas (
        .clk        (clk),
        .rst_n      (rst_n),
        .luma       (luma_smp),
        .gain_win   (gain_win),
        .active_vid (active_vid),
        .freeze     (vblank),
        .agc_en     (agc_en),
        .win_end    (win_end),
        .sync_min   (sync_min),
        .peak_flag  (peak_flag)
    );

    vlc_gain_loop #(
        .SMP_W    (SMP_W),
        .GAIN_W   (GAIN_W),
        .GAIN_MIN (GAIN_MIN),
        .GAIN_MAX (GAIN_MAX),
        .GAIN_NOM (GAIN_NOM),
        .STEP     (GAIN_STEP),
        .SYNC_TGT (SYNC_TGT),
        .DEAD     (SYNC_DEAD)
    ) u_loop (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (vblank),
        .agc_en    (agc_en),
        .man_gain  (man_luma_gain),
        .win_end   (win_end),
        .sync_min  (sync_min),
        .peak_flag (peak_flag),
        .gain      (luma_gain)
    );

    // Copy the static chroma gain, held during blanking.
    always_ff @(posedge clk) begin
        if (!rst_n)       chroma_gain <= G_NOM;
        else if (!vblank) chroma_gain <= man_chroma_gain;
    end

    // R9: the chroma gain copies its register value one edge later outside blanking.
    a_r9_chroma_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |=> (chroma_gain == $past(man_chroma_gain)));

    // R4: blanking holds the chroma gain.
    a_r4_chroma_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> $stable(chroma_gain));
endmodule

// File: tb/vid_level_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected outputs, a falling-edge monitor compares them.
module vid_level_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] luma_smp = 8'd100;
    logic [7:0] chroma_smp = 8'd128;
    logic       clamp_win = 1'b0;
    logic       gain_win = 1'b0;
    logic       vblank = 1'b0;
    logic       active_vid = 1'b0;
    logic       agc_en = 1'b1;
    logic [8:0] man_luma_gain = 9'd256;
    logic [8:0] man_chroma_gain = 9'd100;
    logic       luma_clamp_up, luma_clamp_dn, chroma_clamp_up, chroma_clamp_dn;
    logic [8:0] luma_gain, chroma_gain;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        int    sel;
        int    val;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    vid_level_ctrl u_vid_level_ctrl (
        .clk(clk), .rst_n(rst_n), .luma_smp(luma_smp), .chroma_smp(chroma_smp),
        .clamp_win(clamp_win), .gain_win(gain_win), .vblank(vblank),
        .active_vid(active_vid), .agc_en(agc_en), .man_luma_gain(man_luma_gain),
        .man_chroma_gain(man_chroma_gain), .luma_clamp_up(luma_clamp_up),
        .luma_clamp_dn(luma_clamp_dn), .chroma_clamp_up(chroma_clamp_up),
        .chroma_clamp_dn(chroma_clamp_dn), .luma_gain(luma_gain),
        .chroma_gain(chroma_gain)
    );

    function automatic int get_out(int sel);
        case (sel)
            0: return int'(luma_clamp_up);
            1: return int'(luma_clamp_dn);
            2: return int'(chroma_clamp_up);
            3: return int'(chroma_clamp_dn);
            4: return int'(luma_gain);
            default: return int'(chroma_gain);
        endcase
    endfunction

    // Monitor: compare every queued expectation at the falling edge.
    always @(negedge clk) begin
        exp_t e;
        int   act;
        while (exp_q.size() > 0) begin
            e   = exp_q.pop_front();
            act = get_out(e.sel);
            n_cmp++;
            if (act != e.val) begin
                n_bad++;
                $display("FAIL %s output=%0d actual=%0d expected=%0d", e.req, e.sel, act, e.val);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string r, int sel, int val);
        exp_t e;
        e.req = r; e.sel = sel; e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic expect_clamp(string r, int lu, int ld, int cu, int cd);
        expect_out(r, 0, lu); expect_out(r, 1, ld);
        expect_out(r, 2, cu); expect_out(r, 3, cd);
    endtask

    // One line: an active-video sample, a two-sample gain window, then the window end.
    task automatic run_line(int sync, bit pk, string r, int exp_lg);
        active_vid = 1'b1; luma_smp = pk ? 8'd255 : 8'd100; tick();
        active_vid = 1'b0; gain_win = 1'b1; luma_smp = 8'(sync + 5); tick();
        luma_smp = 8'(sync); tick();
        gain_win = 1'b0; luma_smp = 8'd100; tick();
        expect_out(r, 4, exp_lg);
    endtask

    initial begin
        // R10: reset state.
        tick(); tick();
        expect_clamp("R10", 0, 0, 0, 0);
        expect_out("R10", 4, 256);
        expect_out("R10", 5, 256);
        rst_n = 1'b1; tick();
        expect_out("R9", 5, 100);

        // R1 and R2: compare against 60 and 128.
        clamp_win = 1'b1; luma_smp = 8'd59; chroma_smp = 8'd128; tick();
        expect_clamp("R1", 1, 0, 0, 0);
        luma_smp = 8'd60; chroma_smp = 8'd200; tick();
        expect_clamp("R2", 0, 0, 0, 1);
        luma_smp = 8'd61; chroma_smp = 8'd0; tick();
        expect_clamp("R1", 0, 1, 1, 0);
        luma_smp = 8'd255; chroma_smp = 8'd127; tick();
        expect_clamp("R2", 0, 1, 1, 0);

        // R3: window low clears requests.
        clamp_win = 1'b0; luma_smp = 8'd0; chroma_smp = 8'd0; tick();
        expect_clamp("R3", 0, 0, 0, 0);

        // R4: blanking holds clamp outputs and chroma gain.
        clamp_win = 1'b1; tick();
        expect_clamp("R1", 1, 0, 1, 0);
        vblank = 1'b1; luma_smp = 8'd255; chroma_smp = 8'd255; man_chroma_gain = 9'd50; tick();
        expect_clamp("R4", 1, 0, 1, 0);
        expect_out("R4", 5, 100);
        clamp_win = 1'b0; tick();
        expect_clamp("R4", 1, 0, 1, 0);
        vblank = 1'b0; tick();
        expect_clamp("R3", 0, 0, 0, 0);
        expect_out("R9", 5, 50);

        // R5 and R6: sync-level stepping and dead band.
        run_line(10, 1'b0, "R5", 260);
        run_line(16, 1'b0, "R6", 260);
        run_line(20, 1'b0, "R6", 256);
        run_line(14, 1'b0, "R6", 256);
        run_line(18, 1'b0, "R6", 256);
        run_line(13, 1'b0, "R5", 260);
        run_line(19, 1'b0, "R6", 256);

        // R8: overshoot overrides a low sync and is consumed once.
        run_line(10, 1'b1, "R8", 252);
        run_line(16, 1'b0, "R8", 252);

        // R4: a whole line in blanking changes nothing, and its overshoot is ignored.
        vblank = 1'b1;
        run_line(10, 1'b1, "R4", 252);
        vblank = 1'b0;
        run_line(16, 1'b0, "R4", 252);

        // R7: saturation at the top and bottom.
        agc_en = 1'b0; man_luma_gain = 9'd494; tick();
        expect_out("R9", 4, 494);
        agc_en = 1'b1;
        run_line(10, 1'b0, "R7", 496);
        run_line(10, 1'b0, "R7", 496);
        agc_en = 1'b0; man_luma_gain = 9'd18; tick();
        expect_out("R9", 4, 18);
        agc_en = 1'b1;
        run_line(30, 1'b0, "R7", 16);
        run_line(30, 1'b0, "R7", 16);

        // R9: manual mode ignores windows and clears the overshoot flag.
        agc_en = 1'b0; man_luma_gain = 9'd300; tick();
        expect_out("R9", 4, 300);
        run_line(10, 1'b0, "R9", 300);
        run_line(16, 1'b1, "R9", 300);
        agc_en = 1'b1;
        run_line(16, 1'b0, "R9", 300);
        run_line(10, 1'b0, "R9", 304);

        @(negedge clk); #1;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule